// File: doc/BRIEF.md
# Narrow-to-wide memory port converter

This block joins a narrow user memory port to a native memory port whose data width is an integer multiple of the user width. Both sides use three valid/ready channels: a command channel (write flag and address), a write-data channel (data and byte enables) and a read-data channel. The user address selects both a native word and a lane inside it. Writes that land in the same native word are merged in a holding buffer and leave as one native write. Reads fetch the native word and return only the addressed lane.

The holding buffer is emptied in three cases: all its lanes have been written, a write arrives for another native word, or any read arrives. Flushing before every read means a read always sees the data written before it. Read responses return to the user in command order.

Top module: `mem_upsize_conv`

## Requirements
- R1: With ratio K = NW/UW, the user address A maps to native address A/K and lane A mod K. A width pair where NW is not a multiple of UW, or where K is below 2, is rejected at elaboration.
- R2: Lane 0 takes native bits [UW-1:0]. Lane j takes bits [j*UW +: UW], so the lowest user address sits in the least significant bits.
- R3: Native byte enables are set only for bytes that a buffered user write enabled. A user write with all enables at 0 leaves memory unchanged, and writing one lane leaves the other lanes of that native word untouched.
- R4: A user write is a command handshake followed by a separate write-data handshake. In idle, u_cmd_ready is 1 and u_wd_ready is 0. Once a write command is accepted to the buffered word, or to an empty buffer, u_wd_ready is 1 and u_cmd_ready is 0 in the next cycle.
- R5: Writes to one native word are merged into a single native write. That write goes out when the last lane is filled, or when a write to a different native word arrives. The native command and write data stay stable while they wait for ready.
- R6: Reading a user address returns exactly the narrow word last written there. Native words that were never written read as zero.
- R7: Read data reaches the user in the order of the read commands. u_rd_valid and u_rd_data are held until u_rd_ready is seen.
- R8: A read command first flushes any buffered write data, so no native read is issued while the buffer holds data.
- R9: After reset, all valid outputs are 0, u_cmd_ready is 1 and u_wd_ready is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| u_cmd_valid | input | 1 | User command valid |
| u_cmd_ready | output | 1 | User command ready |
| u_cmd_we | input | 1 | User command is a write |
| u_cmd_addr | input | AW | User word address |
| u_wd_valid | input | 1 | User write data valid |
| u_wd_ready | output | 1 | User write data ready |
| u_wd_data | input | UW | User write data |
| u_wd_be | input | UW/8 | User byte enables |
| u_rd_valid | output | 1 | User read data valid |
| u_rd_ready | input | 1 | User read data ready |
| u_rd_data | output | UW | User read data |
| n_cmd_valid | output | 1 | Native command valid |
| n_cmd_ready | input | 1 | Native command ready |
| n_cmd_we | output | 1 | Native command is a write |
| n_cmd_addr | output | AW-log2(NW/UW) | Native word address |
| n_wd_valid | output | 1 | Native write data valid |
| n_wd_ready | input | 1 | Native write data ready |
| n_wd_data | output | NW | Native write data |
| n_wd_be | output | NW/8 | Native byte enables |
| n_rd_valid | input | 1 | Native read data valid |
| n_rd_ready | output | 1 | Native read data ready |
| n_rd_data | input | NW | Native read data |

## Verification
The hardest case to reach is a partly filled buffer that has to be flushed by something other than its own last lane. The stimulus ends a group on a single lane and then writes to another native word, so the first word goes out incomplete. It then issues a read while a lone lane is still buffered, and compares the native write count before and after that read. Order and hold are tested by issuing two reads without taking the first response, which leaves the second native response stalled behind the held output.

// File: rtl/upsz_pkg.sv
package upsz_pkg;
  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_WDAT  = 2'd1,
    S_FLUSH = 2'd2,
    S_RCMD  = 2'd3
  } upsz_state_t;
endpackage

// File: rtl/upsz_gather.sv
module upsz_gather #(
  parameter int UW = 8,
  parameter int NW = 32,
  parameter int AW = 10
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          put,
  input  logic [$clog2(NW/UW)-1:0]      put_lane,
  input  logic [AW-$clog2(NW/UW)-1:0]   put_naddr,
  input  logic [UW-1:0]                 put_data,
  input  logic [UW/8-1:0]               put_be,
  input  logic                          clr,
  output logic                          hold,
  output logic [AW-$clog2(NW/UW)-1:0]   naddr,
  output logic [NW-1:0]                 data,
  output logic [NW/8-1:0]               be,
  output logic                          last_fill
);
  localparam int RATIO = NW / UW;
  localparam int LB    = $clog2(RATIO);
  localparam int UBE   = UW / 8;

  logic [RATIO-1:0] mask;

  assign last_fill = &(mask | (RATIO'(1) << put_lane));

  always_ff @(posedge clk) begin
    if (rst) begin
      hold  <= 1'b0;
      mask  <= '0;
      naddr <= '0;
      data  <= '0;
      be    <= '0;
    end else if (clr) begin
      hold <= 1'b0;
      mask <= '0;
      be   <= '0;
    end else if (put) begin
      hold           <= 1'b1;
      naddr          <= put_naddr;
      mask[put_lane] <= 1'b1;
      for (int l = 0; l < RATIO; l++) begin
        for (int b = 0; b < UBE; b++) begin
          if (put_lane == LB'(l) && put_be[b]) begin
            data[l*UW + b*8 +: 8] <= put_data[b*8 +: 8];
            be[l*UBE + b]         <= 1'b1;
          end
        end
      end
    end
  end

  // R3
  empty_no_enable_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (be == '0));
endmodule

// File: rtl/upsz_rd_ret.sv
module upsz_rd_ret #(
  parameter int UW    = 8,
  parameter int NW    = 32,
  parameter int DEPTH = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      push,
  input  logic [$clog2(NW/UW)-1:0]  push_lane,
  output logic                      full,
  input  logic                      n_rd_valid,
  output logic                      n_rd_ready,
  input  logic [NW-1:0]             n_rd_data,
  output logic                      u_rd_valid,
  input  logic                      u_rd_ready,
  output logic [UW-1:0]             u_rd_data
);
  localparam int LB = $clog2(NW / UW);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [LB-1:0] lanes [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic          pop;

  assign full       = (cnt == CW'(DEPTH));
  assign n_rd_ready = !u_rd_valid;
  assign pop        = n_rd_valid && n_rd_ready;

  always_ff @(posedge clk) begin
    if (push) lanes[wptr] <= push_lane;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr       <= '0;
      rptr       <= '0;
      cnt        <= '0;
      u_rd_valid <= 1'b0;
      u_rd_data  <= '0;
    end else begin
      if (push) wptr <= (wptr == PW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == PW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      if (push && !pop)      cnt <= cnt + 1'b1;
      else if (pop && !push) cnt <= cnt - 1'b1;
      if (pop) begin
        u_rd_valid <= 1'b1;
        u_rd_data  <= n_rd_data[lanes[rptr]*UW +: UW];
      end else if (u_rd_ready) begin
        u_rd_valid <= 1'b0;
      end
    end
  end

  // R7
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (u_rd_valid && !u_rd_ready) |=> (u_rd_valid && $stable(u_rd_data)));
  // R7
  no_orphan_chk: assert property (@(posedge clk) disable iff (rst)
    pop |-> (cnt != '0));
  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
endmodule

// File: rtl/mem_upsize_conv.sv
module mem_upsize_conv
  import upsz_pkg::*;
#(
  parameter int UW    = 8,
  parameter int NW    = 32,
  parameter int AW    = 10,
  parameter int RDQ   = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         u_cmd_valid,
  output logic                         u_cmd_ready,
  input  logic                         u_cmd_we,
  input  logic [AW-1:0]                u_cmd_addr,
  input  logic                         u_wd_valid,
  output logic                         u_wd_ready,
  input  logic [UW-1:0]                u_wd_data,
  input  logic [UW/8-1:0]              u_wd_be,
  output logic                         u_rd_valid,
  input  logic                         u_rd_ready,
  output logic [UW-1:0]                u_rd_data,
  output logic                         n_cmd_valid,
  input  logic                         n_cmd_ready,
  output logic                         n_cmd_we,
  output logic [AW-$clog2(NW/UW)-1:0]  n_cmd_addr,
  output logic                         n_wd_valid,
  input  logic                         n_wd_ready,
  output logic [NW-1:0]                n_wd_data,
  output logic [NW/8-1:0]              n_wd_be,
  input  logic                         n_rd_valid,
  output logic                         n_rd_ready,
  input  logic [NW-1:0]                n_rd_data
);
  localparam int RATIO = NW / UW;
  localparam int LB    = $clog2(RATIO);
  localparam int NAW   = AW - LB;

  // R1
  if (NW % UW != 0) begin : g_bad_ratio
    $error("native width must be an integer multiple of user width");
  end
  if (RATIO < 2 || (1 << LB) != RATIO) begin : g_bad_pow
    $error("width ratio must be a power of two of at least 2");
  end
  if (UW % 8 != 0) begin : g_bad_bytes
    $error("user width must be a whole number of bytes");
  end

  upsz_state_t st, after;
  logic [AW-1:0] p_addr;
  logic          c_done, w_done;

  logic          g_hold, g_last, g_put, g_clr, rd_full, rd_push;
  logic [NAW-1:0] g_naddr;
  logic          cmd_hs, ucmd_hs, uwd_hs, nwd_hs;

  assign u_cmd_ready = (st == S_IDLE);
  assign u_wd_ready  = (st == S_WDAT);
  assign n_cmd_valid = ((st == S_FLUSH) && !c_done) || ((st == S_RCMD) && !rd_full);
  assign n_cmd_we    = (st == S_FLUSH);
  assign n_cmd_addr  = (st == S_FLUSH) ? g_naddr : p_addr[AW-1:LB];
  assign n_wd_valid  = (st == S_FLUSH) && !w_done;

  assign ucmd_hs = u_cmd_valid && u_cmd_ready;
  assign uwd_hs  = u_wd_valid && u_wd_ready;
  assign cmd_hs  = n_cmd_valid && n_cmd_ready;
  assign nwd_hs  = n_wd_valid && n_wd_ready;
  assign g_put   = uwd_hs;
  assign g_clr   = (st == S_FLUSH) && (c_done || cmd_hs) && (w_done || nwd_hs);
  assign rd_push = (st == S_RCMD) && cmd_hs;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      after  <= S_IDLE;
      p_addr <= '0;
      c_done <= 1'b0;
      w_done <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (ucmd_hs) begin
          p_addr <= u_cmd_addr;
          if (u_cmd_we) begin
            if (g_hold && g_naddr != u_cmd_addr[AW-1:LB]) begin
              st    <= S_FLUSH;
              after <= S_WDAT;
            end else begin
              st <= S_WDAT;
            end
          end else if (g_hold) begin
            st    <= S_FLUSH;
            after <= S_RCMD;
          end else begin
            st <= S_RCMD;
          end
        end
        S_WDAT: if (uwd_hs) begin
          if (g_last) begin
            st    <= S_FLUSH;
            after <= S_IDLE;
          end else begin
            st <= S_IDLE;
          end
        end
        S_FLUSH: begin
          if (g_clr) begin
            c_done <= 1'b0;
            w_done <= 1'b0;
            st     <= after;
          end else begin
            if (cmd_hs) c_done <= 1'b1;
            if (nwd_hs) w_done <= 1'b1;
          end
        end
        S_RCMD: if (cmd_hs) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  upsz_gather #(.UW(UW), .NW(NW), .AW(AW)) u_gather (
    .clk       (clk),
    .rst       (rst),
    .put       (g_put),
    .put_lane  (p_addr[LB-1:0]),
    .put_naddr (p_addr[AW-1:LB]),
    .put_data  (u_wd_data),
    .put_be    (u_wd_be),
    .clr       (g_clr),
    .hold      (g_hold),
    .naddr     (g_naddr),
    .data      (n_wd_data),
    .be        (n_wd_be),
    .last_fill (g_last)
  );

  upsz_rd_ret #(.UW(UW), .NW(NW), .DEPTH(RDQ)) u_rdret (
    .clk        (clk),
    .rst        (rst),
    .push       (rd_push),
    .push_lane  (p_addr[LB-1:0]),
    .full       (rd_full),
    .n_rd_valid (n_rd_valid),
    .n_rd_ready (n_rd_ready),
    .n_rd_data  (n_rd_data),
    .u_rd_valid (u_rd_valid),
    .u_rd_ready (u_rd_ready),
    .u_rd_data  (u_rd_data)
  );

  // R5
  ncmd_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (n_cmd_valid && !n_cmd_ready) |=> (n_cmd_valid && $stable(n_cmd_addr) && $stable(n_cmd_we)));
  // R5
  nwd_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (n_wd_valid && !n_wd_ready) |=> (n_wd_valid && $stable(n_wd_data) && $stable(n_wd_be)));
  // R8
  read_after_flush_chk: assert property (@(posedge clk) disable iff (rst)
    (n_cmd_valid && !n_cmd_we) |-> !g_hold);
  // R4
  wd_after_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(u_wd_ready) |-> $past(st == S_FLUSH || ucmd_hs));
endmodule

// File: tb/sim_mem_upsize_conv.sv
module sim_mem_upsize_conv;
  localparam int CLK_NS = 10;
  localparam int UW = 8, NW = 32, AW = 10, NAW = 8, MD = 8;
  localparam int NV = 10;
  localparam logic [17:0] VEC [NV] = '{
    {10'd10, 8'hA1}, {10'd8, 8'hB2}, {10'd11, 8'hC3}, {10'd9, 8'hD4},
    {10'd0, 8'h15},  {10'd1, 8'h26}, {10'd2, 8'h37},  {10'd3, 8'h48},
    {10'd21, 8'h59}, {10'd6, 8'h6A}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic u_cmd_valid = 0, u_cmd_we = 0, u_wd_valid = 0, u_rd_ready = 0;
  logic [AW-1:0] u_cmd_addr = '0;
  logic [UW-1:0] u_wd_data = '0;
  logic [0:0]    u_wd_be = '0;
  logic u_cmd_ready, u_wd_ready, u_rd_valid;
  logic [UW-1:0] u_rd_data;
  logic n_cmd_valid, n_cmd_ready, n_cmd_we, n_wd_valid, n_wd_ready, n_rd_valid, n_rd_ready;
  logic [NAW-1:0] n_cmd_addr;
  logic [NW-1:0]  n_wd_data, n_rd_data;
  logic [3:0]     n_wd_be;

  int n_chk = 0, n_fail = 0, n_wr = 0;
  logic [NW-1:0] mem [MD];
  logic [NW-1:0] exp_mem [MD];
  logic [1:0]    m_st;
  logic [2:0]    m_addr;
  logic [NW-1:0] m_rdata;

  always #(CLK_NS/2) clk = ~clk;

  mem_upsize_conv #(.UW(UW), .NW(NW), .AW(AW)) u0 (.*);

  assign n_cmd_ready = (m_st == 2'd0) && !rst;
  assign n_wd_ready  = (m_st == 2'd1);
  assign n_rd_valid  = (m_st == 2'd2);
  assign n_rd_data   = m_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      m_st <= 2'd0; m_addr <= '0; m_rdata <= '0; n_wr <= 0;
      for (int i = 0; i < MD; i++) mem[i] <= '0;
    end else begin
      if (n_cmd_valid && n_cmd_ready) begin
        if (n_cmd_we) begin
          m_st <= 2'd1; m_addr <= n_cmd_addr[2:0]; n_wr <= n_wr + 1;
        end else begin
          m_st <= 2'd2; m_rdata <= mem[n_cmd_addr[2:0]];
        end
      end
      if (n_wd_valid && n_wd_ready) begin
        for (int b = 0; b < 4; b++)
          if (n_wd_be[b]) mem[m_addr][b*8 +: 8] <= n_wd_data[b*8 +: 8];
        m_st <= 2'd0;
      end
      if (n_rd_valid && n_rd_ready) m_st <= 2'd0;
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic do_wr(input logic [AW-1:0] a, input logic [7:0] d, input logic be);
    u_cmd_valid = 1; u_cmd_we = 1; u_cmd_addr = a;
    while (!u_cmd_ready) @(negedge clk);
    @(negedge clk); u_cmd_valid = 0;
    u_wd_valid = 1; u_wd_data = d; u_wd_be = be;
    while (!u_wd_ready) @(negedge clk);
    @(negedge clk); u_wd_valid = 0;
  endtask

  task automatic rd_cmd(input logic [AW-1:0] a);
    u_cmd_valid = 1; u_cmd_we = 0; u_cmd_addr = a;
    while (!u_cmd_ready) @(negedge clk);
    @(negedge clk); u_cmd_valid = 0;
  endtask

  task automatic rd_get(output logic [7:0] d);
    while (!u_rd_valid) @(negedge clk);
    d = u_rd_data; u_rd_ready = 1;
    @(negedge clk); u_rd_ready = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    summary();
  end

  initial begin
    logic [7:0] d, d2;
    for (int i = 0; i < MD; i++) exp_mem[i] = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R9 reset state
    chk(u_cmd_ready && !u_wd_ready && !u_rd_valid && !n_cmd_valid && !n_wd_valid,
        "R9 reset", {28'd0, u_cmd_ready, u_wd_ready, u_rd_valid, n_cmd_valid}, 32'h8);

    for (int i = 0; i < NV; i++) begin
      do_wr(VEC[i][17:8], VEC[i][7:0], 1'b1);
      exp_mem[VEC[i][17:10]][VEC[i][9:8]*8 +: 8] = VEC[i][7:0];
    end
    repeat (4) @(negedge clk);
    // R5: two full groups plus the lone lane flushed by a write elsewhere
    chk(n_wr == 3, "R5 merged write count", n_wr, 3);
    chk(mem[1] == 0, "R5 lone lane still buffered", mem[1], 0);

    for (int i = 0; i < NV; i++) begin
      rd_cmd(VEC[i][17:8]);
      rd_get(d);
      chk(d == VEC[i][7:0], "R6 readback", d, VEC[i][7:0]);
      if (i == 0) chk(n_wr == 4, "R8 read flushes buffer", n_wr, 4);
    end
    for (int i = 0; i < MD; i++)
      chk(mem[i] == exp_mem[i], "R1 R2 packed native word", mem[i], exp_mem[i]);
    rd_cmd(10'd30); rd_get(d);
    chk(d == 0, "R6 unwritten reads zero", d, 0);

    // R3: disabled write and single lane update
    do_wr(10'd0, 8'hEE, 1'b0);
    do_wr(10'd9, 8'h5A, 1'b1);
    exp_mem[2][15:8] = 8'h5A;
    rd_cmd(10'd0); rd_get(d);
    chk(d == 8'h15, "R3 zero-enable write ignored", d, 8'h15);
    chk(mem[0] == exp_mem[0], "R3 word0 unchanged", mem[0], exp_mem[0]);
    chk(mem[2] == exp_mem[2], "R3 only lane1 changed", mem[2], exp_mem[2]);

    // R4 two-phase user write
    chk(!u_wd_ready, "R4 idle wd ready", u_wd_ready, 0);
    u_cmd_valid = 1; u_cmd_we = 1; u_cmd_addr = 10'd12;
    @(negedge clk); u_cmd_valid = 0;
    chk(u_wd_ready && !u_cmd_ready, "R4 wd phase", {u_wd_ready, u_cmd_ready}, 2'b10);
    u_wd_valid = 1; u_wd_data = 8'h7C; u_wd_be = 1;
    @(negedge clk); u_wd_valid = 0;

    // R7 hold and order
    rd_cmd(10'd8);
    rd_cmd(10'd3);
    repeat (6) @(negedge clk);
    chk(u_rd_valid && u_rd_data == 8'hB2, "R7 held response", {u_rd_valid, u_rd_data}, 9'h1B2);
    rd_get(d);
    rd_get(d2);
    chk(d2 == 8'h48, "R7 second response in order", d2, 8'h48);
    rd_cmd(10'd12); rd_get(d);
    chk(d == 8'h7C, "R6 readback after flush", d, 8'h7C);
    summary();
  end
endmodule